// File: doc/BRIEF.md
# DMA Channel Interrupt Status and Mask Unit

This unit collects completion and fault events from a set of DMA channels and turns them into processor interrupt requests. Each channel has two event inputs. A completion event is a single-cycle pulse sent when the channel's transfer count reaches zero. A fault event is a single-cycle pulse sent when the channel's transfer fails. Each pulse sets a sticky bit in one of two raw status vectors. That bit stays set until software clears it.

Each raw status vector has its own enable vector, and a bit set to one lets that channel's event through. The AND of raw status and enable gives the pending set. Three registered request lines are driven from the pending sets: one for completion, one for faults, and a third that is the OR of the other two. The third line is for interrupt controllers with few inputs. Software uses a small register port to do four things: read the raw status even while it is masked, read the masked status, program the enables, and clear status bits by writing ones.

Top module: `dmairq_top`

## Requirements
- R1: After reset, every raw status bit and every enable bit is zero, all eight register addresses read zero, and `irq_tc`, `irq_err` and `irq_any` are low.
- R2: A one-cycle pulse on bit i of `tc_evt` or `err_evt` sets bit i of the matching raw status at the next clock edge. The bit then stays set for as long as no clear reaches it.
- R3: A write of value V to the completion clear address (3) or the fault clear address (7) clears exactly the raw bits where V is one. Bits where V is zero are left as they were.
- R4: When an event pulse and a clear of the same bit fall in the same cycle, the bit ends up set.
- R5: Reading the raw address (completion 0, fault 4) returns the raw status whatever the enable bits hold.
- R6: Reading the masked address (completion 1, fault 5) returns raw status AND enable. Writing the enable address (completion 2, fault 6) loads the enable vector, and reading that address returns it. An enable bit of one lets the channel through.
- R7: `irq_tc` is high in a cycle exactly when, one clock edge earlier, some completion bit was both raw-set and enabled.
- R8: `irq_err` follows the same one-edge rule for the fault raw status and the fault enable.
- R9: `irq_any` equals `irq_tc` OR `irq_err` in every cycle.
- R10: The completion enables and the fault enables are independent. Writing one vector changes neither the other vector nor the request line of the other source.
- R11: The raw and masked addresses (0, 1, 4, 5) are read-only, so writes to them have no effect. The clear addresses (3, 7) read as zero. Read data is combinational from the current state and `reg_addr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; asserts asynchronously and is released synchronously inside the block |
| tc_evt | input | NCH | Per-channel completion event pulses |
| err_evt | input | NCH | Per-channel fault event pulses |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | NCH | Register write data |
| reg_rdata | output | NCH | Register read data for `reg_addr` |
| irq_tc | output | 1 | Completion interrupt request |
| irq_err | output | 1 | Fault interrupt request |
| irq_any | output | 1 | Combined interrupt request |

## Verification
The assertions assume that every event input is a clean synchronous pulse that is valid at the clock edge. They also assume that the write strobe applies to one address per cycle, so that a single cycle never holds both a clear and an enable update for the same source. The stimulus drives events and register accesses only at the falling edge, which keeps every input stable around the sampling edge. It also crafts the set-versus-clear collision on purpose and leaves nothing to chance. A random phase then mixes sparse events with writes to arbitrary addresses, including the read-only ones, and a cycle-level model predicts the read data and the three request lines.

// File: rtl/dmairq_pkg.sv
package dmairq_pkg;

  localparam int unsigned SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_TC_RAW = 3'd0,
    SEL_TC_MSK = 3'd1,
    SEL_TC_ENA = 3'd2,
    SEL_TC_CLR = 3'd3,
    SEL_ER_RAW = 3'd4,
    SEL_ER_MSK = 3'd5,
    SEL_ER_ENA = 3'd6,
    SEL_ER_CLR = 3'd7
  } dmairq_sel_e;

  localparam int unsigned NSRC   = 2;
  localparam int unsigned SRC_TC = 0;
  localparam int unsigned SRC_ER = 1;

endpackage

// File: rtl/dmairq_src_bank.sv
module dmairq_src_bank #(
  parameter int unsigned NCH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] evt,
  input  logic           clr_we,
  input  logic           ena_we,
  input  logic [NCH-1:0] wdata,
  output logic [NCH-1:0] raw,
  output logic [NCH-1:0] ena,
  output logic           pend
);

  logic [NCH-1:0] raw_q, raw_d;
  logic [NCH-1:0] ena_q, ena_d;
  logic [NCH-1:0] clr_mask;
  logic           raw_upd;

  // next-state: clear first, then set, so a coincident event survives
  always_comb begin
    clr_mask = clr_we ? wdata : '0;
    raw_d    = (raw_q & ~clr_mask) | evt;
    raw_upd  = clr_we | (|evt);
    ena_d    = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q <= '0;
    end else if (raw_upd) begin
      raw_q <= raw_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ena_q <= '0;
    end else if (ena_we) begin
      ena_q <= ena_d;
    end
  end

  assign raw  = raw_q;
  assign ena  = ena_q;
  assign pend = |(raw_q & ena_q);

  // R2 / R4: any pulsed bit is set after the edge, even under a clear
  p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((raw & $past(evt)) == $past(evt)));

  // R2: without a clear no bit is lost
  p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_we |=> ((raw & $past(raw)) == $past(raw)));

  // R3: cleared bits without a coincident event are gone
  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((raw & $past(wdata & ~evt)) == '0));

  // R10: enables only move on their own write strobe
  p_ena_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ena_we |=> $stable(ena));

endmodule

// File: rtl/dmairq_regif.sv
module dmairq_regif
  import dmairq_pkg::*;
#(
  parameter int unsigned NCH = 8
) (
  input  logic                       reg_wr,
  input  logic [SEL_W-1:0]           reg_addr,
  input  logic [NSRC-1:0][NCH-1:0]   raw,
  input  logic [NSRC-1:0][NCH-1:0]   ena,
  output logic [NSRC-1:0]            clr_we,
  output logic [NSRC-1:0]            ena_we,
  output logic [NCH-1:0]             reg_rdata
);

  dmairq_sel_e sel;

  always_comb begin
    sel = dmairq_sel_e'(reg_addr);
  end

  // write strobes per source
  always_comb begin
    clr_we = '0;
    ena_we = '0;
    if (reg_wr) begin
      unique case (sel)
        SEL_TC_CLR: clr_we[SRC_TC] = 1'b1;
        SEL_ER_CLR: clr_we[SRC_ER] = 1'b1;
        SEL_TC_ENA: ena_we[SRC_TC] = 1'b1;
        SEL_ER_ENA: ena_we[SRC_ER] = 1'b1;
        default: ;
      endcase
    end
  end

  // read mux
  always_comb begin
    unique case (sel)
      SEL_TC_RAW: reg_rdata = raw[SRC_TC];
      SEL_TC_MSK: reg_rdata = raw[SRC_TC] & ena[SRC_TC];
      SEL_TC_ENA: reg_rdata = ena[SRC_TC];
      SEL_ER_RAW: reg_rdata = raw[SRC_ER];
      SEL_ER_MSK: reg_rdata = raw[SRC_ER] & ena[SRC_ER];
      SEL_ER_ENA: reg_rdata = ena[SRC_ER];
      default:    reg_rdata = '0;
    endcase
  end

  // R11: a single strobe per cycle at most
  always_comb begin
    a_one_strobe_r11: assert ($countones({clr_we, ena_we}) <= 1);
  end

endmodule

// File: rtl/dmairq_irq_out.sv
module dmairq_irq_out (
  input  logic clk,
  input  logic rst_n,
  input  logic tc_pend,
  input  logic err_pend,
  output logic irq_tc,
  output logic irq_err,
  output logic irq_any
);

  logic tc_q, err_q, any_q;
  logic tc_d, err_d, any_d;

  always_comb begin
    tc_d  = tc_pend;
    err_d = err_pend;
    any_d = tc_pend | err_pend;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tc_q  <= 1'b0;
      err_q <= 1'b0;
      any_q <= 1'b0;
    end else begin
      tc_q  <= tc_d;
      err_q <= err_d;
      any_q <= any_d;
    end
  end

  assign irq_tc  = tc_q;
  assign irq_err = err_q;
  assign irq_any = any_q;

  p_tc_lag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_tc == $past(tc_pend)));

  p_err_lag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_err == $past(err_pend)));

  p_any_or_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_any == (irq_tc | irq_err));

endmodule

// File: rtl/dmairq_top.sv
module dmairq_top
  import dmairq_pkg::*;
#(
  parameter int unsigned NCH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   tc_evt,
  input  logic [NCH-1:0]   err_evt,
  input  logic             reg_wr,
  input  logic [SEL_W-1:0] reg_addr,
  input  logic [NCH-1:0]   reg_wdata,
  output logic [NCH-1:0]   reg_rdata,
  output logic             irq_tc,
  output logic             irq_err,
  output logic             irq_any
);

  localparam int unsigned SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
    end
  end

  assign rst_int_n = rst_sync_q[SYNC_STAGES-1];

  logic [NSRC-1:0][NCH-1:0] evt_v;
  logic [NSRC-1:0][NCH-1:0] raw_v;
  logic [NSRC-1:0][NCH-1:0] ena_v;
  logic [NSRC-1:0]          clr_we;
  logic [NSRC-1:0]          ena_we;
  logic [NSRC-1:0]          pend_v;

  always_comb begin
    evt_v[SRC_TC] = tc_evt;
    evt_v[SRC_ER] = err_evt;
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_bank
    dmairq_src_bank #(.NCH(NCH)) i_bank (
      .clk    (clk),
      .rst_n  (rst_int_n),
      .evt    (evt_v[g]),
      .clr_we (clr_we[g]),
      .ena_we (ena_we[g]),
      .wdata  (reg_wdata),
      .raw    (raw_v[g]),
      .ena    (ena_v[g]),
      .pend   (pend_v[g])
    );
  end

  dmairq_regif #(.NCH(NCH)) i_regif (
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .raw       (raw_v),
    .ena       (ena_v),
    .clr_we    (clr_we),
    .ena_we    (ena_we),
    .reg_rdata (reg_rdata)
  );

  dmairq_irq_out i_out (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .tc_pend  (pend_v[SRC_TC]),
    .err_pend (pend_v[SRC_ER]),
    .irq_tc   (irq_tc),
    .irq_err  (irq_err),
    .irq_any  (irq_any)
  );

  // R10: a write to one enable vector leaves the other untouched
  p_ena_indep_r10: assert property (@(posedge clk) disable iff (!rst_int_n)
    ena_we[SRC_TC] |=> $stable(ena_v[SRC_ER]));

endmodule

// File: tb/test_dmairq_top.sv
module test_dmairq_top;

  localparam int unsigned NCH   = 8;
  localparam time         CLK_P = 10ns;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [NCH-1:0] tc_evt, err_evt, reg_wdata, reg_rdata;
  logic           reg_wr;
  logic [2:0]     reg_addr;
  logic           irq_tc, irq_err, irq_any;

  always #(CLK_P/2) clk = ~clk;

  dmairq_top #(.NCH(NCH)) i_dmairq_top (
    .clk(clk), .rst_n(rst_n), .tc_evt(tc_evt), .err_evt(err_evt),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_tc(irq_tc), .irq_err(irq_err),
    .irq_any(irq_any)
  );

  typedef struct {
    logic [NCH-1:0] rd;
    logic           itc, ier, iany;
    string          tag;
  } item_t;

  item_t q[$];
  item_t cur;
  int    n_run  = 0;
  int    n_fail = 0;
  bit    done   = 1'b0;

  // reference model state
  logic [NCH-1:0] m_tr = '0, m_te = '0, m_er = '0, m_ee = '0;

  function automatic logic [NCH-1:0] mread(input logic [2:0] a);
    case (a)
      3'd0: return m_tr;
      3'd1: return m_tr & m_te;
      3'd2: return m_te;
      3'd4: return m_er;
      3'd5: return m_er & m_ee;
      3'd6: return m_ee;
      default: return '0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [NCH-1:0] act, input logic [NCH-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // driver: apply one cycle of stimulus and push the prediction
  task automatic drive(input logic [NCH-1:0] tc, input logic [NCH-1:0] er,
                       input logic wr, input logic [2:0] a,
                       input logic [NCH-1:0] wd, input string tag);
    item_t it;
    @(negedge clk);
    tc_evt = tc; err_evt = er; reg_wr = wr; reg_addr = a; reg_wdata = wd;
    it.itc  = |(m_tr & m_te);
    it.ier  = |(m_er & m_ee);
    it.iany = it.itc | it.ier;
    m_tr = (m_tr & ~((wr && a == 3'd3) ? wd : '0)) | tc;
    m_er = (m_er & ~((wr && a == 3'd7) ? wd : '0)) | er;
    if (wr && a == 3'd2) m_te = wd;
    if (wr && a == 3'd6) m_ee = wd;
    it.rd  = mread(a);
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic rd(input logic [2:0] a, input string tag);
    drive('0, '0, 1'b0, a, '0, tag);
  endtask

  task automatic wr(input logic [2:0] a, input logic [NCH-1:0] d, input string tag);
    drive('0, '0, 1'b1, a, d, tag);
  endtask

  // monitor: compare after each rising edge
  always @(posedge clk) begin
    #(CLK_P/4);
    if (q.size() > 0) begin
      cur = q.pop_front();
      chk({cur.tag, " rdata"}, reg_rdata, cur.rd);
      chk("R7 irq_tc", NCH'(irq_tc), NCH'(cur.itc));
      chk("R8 irq_err", NCH'(irq_err), NCH'(cur.ier));
      chk("R9 irq_any", NCH'(irq_any), NCH'(cur.iany));
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; tc_evt = '0; err_evt = '0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state through every address
    for (int a = 0; a < 8; a++) rd(3'(a), "R1");

    // R2, R5: masked event still visible raw
    drive(8'h08, '0, 1'b0, 3'd0, '0, "R2");
    rd(3'd0, "R5");
    rd(3'd1, "R6");
    rd(3'd0, "R2");
    // R6: enable, masked view and request
    wr(3'd2, 8'h0C, "R6");
    rd(3'd2, "R6");
    rd(3'd1, "R6");
    rd(3'd1, "R7");
    // R3: clearing an unset bit does nothing, then clear the set one
    wr(3'd3, 8'h04, "R3");
    rd(3'd0, "R3");
    wr(3'd3, 8'h08, "R3");
    rd(3'd0, "R3");
    rd(3'd0, "R7");
    // R4: set and clear in one cycle
    drive(8'h20, '0, 1'b0, 3'd0, '0, "R4");
    drive('0, '0, 1'b1, 3'd3, 8'h20, "R4");
    drive(8'h20, '0, 1'b1, 3'd3, 8'h20, "R4");
    rd(3'd0, "R4");
    // R8: fault source
    drive('0, 8'h81, 1'b0, 3'd4, '0, "R8");
    rd(3'd4, "R5");
    wr(3'd6, 8'h80, "R8");
    rd(3'd5, "R8");
    rd(3'd5, "R9");
    // R10: completion enable writes leave fault side alone
    wr(3'd2, 8'hFF, "R10");
    rd(3'd6, "R10");
    wr(3'd2, 8'h00, "R10");
    rd(3'd6, "R10");
    rd(3'd5, "R10");
    // R11: read-only and write-only addresses
    wr(3'd0, 8'hFF, "R11");
    wr(3'd1, 8'hFF, "R11");
    wr(3'd4, 8'h00, "R11");
    wr(3'd5, 8'h00, "R11");
    rd(3'd0, "R11");
    rd(3'd4, "R11");
    rd(3'd3, "R11");
    rd(3'd7, "R11");
    wr(3'd7, 8'hFF, "R3");
    rd(3'd4, "R3");
    rd(3'd4, "R8");

    // mixed random phase
    for (int i = 0; i < 400; i++) begin
      logic [NCH-1:0] t, e, d;
      logic w;
      t = NCH'($urandom & $urandom & $urandom);
      e = NCH'($urandom & $urandom & $urandom);
      d = NCH'($urandom);
      w = ($urandom % 3) == 0;
      drive(t, e, w, 3'($urandom), d, "R6");
    end

    rd(3'd0, "R2");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule